// File: doc/BRIEF.md
# Channel Command List Walker

This block walks a linked list of 36-bit channel command words held in memory. It feeds a block transfer engine with three things: the current buffer address, the number of words still available, and the direction of the transfer. The block keeps a 22-bit list pointer and reads command words through a one-word memory read port. It decodes each word as one of four kinds: an end-of-list marker, a chain link to another list address, a data transfer, or an undefined code.

While a transfer is running, the drive reports how many words it has used. The block then moves the buffer address and reduces the remaining count. When the count is used up, the block either stops or fetches the next command word, depending on the halt-after-count flag of the current command. If a transfer word carries a zero buffer address, the block does not address memory. On a write it supplies words from a small fixed fill area, and on a read it tells the drive to discard the data.

When the drive finishes, the block sorts out any word-count mismatch. If storing was asked for, or a channel error occurred, it writes a status word and a rebuilt command word into the controller's own channel area.

Top module: `ccl_walker`

## Requirements
- R1: Reset and `chan_reset` both set the list pointer to `CTL_BASE + 4*ctl_num`. They also clear every error flag, zero the remaining count, the buffer address and the saved opcode, and set the halt-after-count flag.
- R2: A command word has its opcode in bits 35:33, its word count in bits 32:22 (the upper half's count sits 4 bits above that half's low end) and its address in bits 21:0. The opcode codes are as follows. 000 ends the list. 001 chains to another list address. 1hr is a transfer, where h (bit 34) means halt after the count and r (bit 33) means reverse direction. 010 and 011 are undefined.
- R3: An end-of-list word loads its address into the list pointer, zeroes the count and sets the halt flag. It also pulses `stopped` for one cycle. `start_fail` pulses with it when no transfer word has yet been fetched since `start`.
- R4: A chain word loads its address into the list pointer and starts a new read at that address at once. Nothing is offered to the drive in between.
- R5: A transfer word raises `offer_valid`, showing its count, its address and its reverse flag. The list pointer then steps by one, modulo 2^22.
- R6: A take of n words lowers the remaining count by |n|. The address moves by n, as a signed value modulo 2^22, unless the address is zero. A forward transfer expects n >= 0 and a reverse transfer expects n <= 0.
- R7: When the count reaches zero, the block pulses `stopped` if the halt flag is set. Otherwise it fetches the next word at the list pointer.
- R8: When the address is zero on a write, `offer_fill` is high, `offer_addr` equals `FILL_BASE` and `offer_cnt` equals min(count, `FILL_WORDS`). When the address is zero on a read, `offer_skip` is high and the full count is offered.
- R9: A take with the wrong sign, or with a magnitude above the remaining count, sets `overrun_err` and pulses `stopped`. The count and address are left unchanged.
- R10: An undefined opcode sets `chan_err` and pulses `stopped`. It also pulses `start_fail` under the same rule as R3.
- R11: On `finish`, if `drive_left` is high or the count is nonzero, `chan_err` is set. The long-count flag is set if the count is nonzero; otherwise the short-count flag is set.
- R12: After `finish`, the block writes two words if `finish_store` is high or `chan_err` is set, and then pulses `finish_done`. The first word is the status word at area+1: {chan_err, overrun, long, short, count!=0, 9'b0, list pointer}. The second is the command word at area+2: {opcode of the last transfer, remaining count, address}. Otherwise the block writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_num | input | 3 | Controller number selecting the channel area |
| chan_reset | input | 1 | Channel reset pulse |
| start | input | 1 | Begin a transfer by fetching at the list pointer |
| start_write | input | 1 | Transfer direction seen by the drive, 1 = write |
| rd_req | output | 1 | Memory read request, one cycle |
| rd_addr | output | 22 | Memory read address |
| rd_data | input | 36 | Memory read data |
| rd_valid | input | 1 | Read data valid |
| offer_valid | output | 1 | Buffer offer to the drive is valid |
| offer_addr | output | 22 | Offered buffer address |
| offer_cnt | output | 11 | Words available in this offer |
| offer_rev | output | 1 | Reverse transfer |
| offer_skip | output | 1 | Discard incoming data |
| offer_fill | output | 1 | Offer points at the fill area |
| take_valid | input | 1 | Drive reports used words |
| take_cnt | input | 12 | Signed count of used words |
| stopped | output | 1 | The walk has ended (pulse) |
| start_fail | output | 1 | No transfer word was found after start (pulse) |
| finish | input | 1 | Drive has finished |
| finish_store | input | 1 | Store status even without an error |
| drive_left | input | 1 | Drive still had blocks to move |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | 22 | Memory write address |
| wr_data | output | 36 | Memory write data |
| finish_done | output | 1 | Finish processing is complete (pulse) |
| list_ptr | output | 22 | Current list pointer |
| chan_err | output | 1 | Channel error flag |
| overrun_err | output | 1 | Overrun error flag |

## Verification
The bench sweeps all four transfer variants against both drive directions and three address classes. One class is the zero address. Another sits near the top of the address space, so a wrong step sign or a missing wrap shows up as a wrong `offer_addr`. Chains of links are checked against the exact read address sequence: a design that stopped on a link, or leaked an offer before the transfer word, fails there. A jump to the last address checks that the list pointer wraps to zero. The bench also checks three error cases. Overruns and wrong-sign takes must leave the count intact in the rebuilt command word. Long and short count mismatches must set the flag that matches. A clean finish without a store request must write nothing.

// File: rtl/ccl_pkg.sv
`timescale 1ns/1ps
package ccl_pkg;
    localparam int AW      = 22;   // physical address width
    localparam int CW      = 11;   // word count width
    localparam int OPW     = 3;    // opcode width
    localparam int WW      = 36;   // memory word width
    localparam int CTLW    = 3;    // controller number width
    localparam int OP_LSB  = CW + AW;
    localparam int CNT_LSB = AW;
    localparam int PADW    = WW - 5 - AW;

    typedef enum logic [1:0] {
        K_END  = 2'd0,
        K_LINK = 2'd1,
        K_MOVE = 2'd2,
        K_BAD  = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [OPW-1:0]   op;
        logic             halt;
        logic             rev;
        logic [CW-1:0]    cnt;
        logic [AW-1:0]    addr;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_REQ  = 3'd1,
        S_WAIT = 3'd2,
        S_ACT  = 3'd3,
        S_WST  = 3'd4,
        S_WCCW = 3'd5,
        S_DONE = 3'd6
    } walk_state_e;

    typedef struct packed {
        logic chan_err;
        logic overrun;
        logic long_wc;
        logic short_wc;
    } walk_flags_t;
endpackage

// File: rtl/ccl_decode.sv
`timescale 1ns/1ps
module ccl_decode
    import ccl_pkg::*;
(
    input  logic [WW-1:0] word,
    output cmd_t          cmd
);
    logic [OPW-1:0] op;

    always_comb begin
        op       = word[OP_LSB +: OPW];
        cmd.op   = op;
        cmd.halt = op[1];
        cmd.rev  = op[0];
        cmd.cnt  = word[CNT_LSB +: CW];
        cmd.addr = word[AW-1:0];
        if (op[2])
            cmd.kind = K_MOVE;
        else if (op[1])
            cmd.kind = K_BAD;
        else if (op[0])
            cmd.kind = K_LINK;
        else
            cmd.kind = K_END;
    end
endmodule

// File: rtl/ccl_offer.sv
`timescale 1ns/1ps
module ccl_offer
    import ccl_pkg::*;
#(
    parameter logic [AW-1:0] FILL_BASE  = '0,
    parameter int            FILL_WORDS = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cnt,
    input  logic          wr_dir,
    output logic [AW-1:0] o_addr,
    output logic [CW-1:0] o_cnt,
    output logic          skip,
    output logic          fill
);
    localparam logic [CW-1:0] FW = CW'(FILL_WORDS);

    logic zero_buf;

    always_comb begin
        zero_buf = (addr == '0);
        fill     = zero_buf && wr_dir;
        skip     = zero_buf && !wr_dir;
        o_addr   = fill ? FILL_BASE : addr;
        if (fill && (cnt > FW))
            o_cnt = FW;
        else
            o_cnt = cnt;
    end
endmodule

// File: rtl/ccl_consume.sv
`timescale 1ns/1ps
module ccl_consume
    import ccl_pkg::*;
(
    input  logic [CW:0]   take,
    input  logic          rev,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] addr,
    output logic          bad,
    output logic [CW-1:0] nxt_cnt,
    output logic [AW-1:0] nxt_addr
);
    logic          neg;
    logic [CW:0]   mag;
    logic          wrong_sign;
    logic          too_many;
    logic [AW-1:0] step;

    always_comb begin
        neg        = take[CW];
        mag        = neg ? (~take + 1'b1) : take;
        wrong_sign = rev ? (!neg && (take != '0)) : neg;
        too_many   = mag > {1'b0, cnt};
        bad        = wrong_sign || too_many;
        nxt_cnt    = cnt - mag[CW-1:0];
        step       = {{(AW-CW-1){take[CW]}}, take};
        nxt_addr   = (addr == '0) ? '0 : (addr + step);
    end
endmodule

// File: rtl/ccl_pack.sv
`timescale 1ns/1ps
module ccl_pack
    import ccl_pkg::*;
(
    input  walk_flags_t    flags,
    input  logic [AW-1:0]  lp,
    input  logic [OPW-1:0] op,
    input  logic [CW-1:0]  cnt,
    input  logic [AW-1:0]  addr,
    output logic [WW-1:0]  stat_word,
    output logic [WW-1:0]  ccw_word
);
    always_comb begin
        stat_word = {flags.chan_err, flags.overrun, flags.long_wc,
                     flags.short_wc, (cnt != '0), {PADW{1'b0}}, lp};
        ccw_word  = {op, cnt, addr};
    end
endmodule

// File: rtl/ccl_walker.sv
`timescale 1ns/1ps
module ccl_walker
    import ccl_pkg::*;
#(
    parameter logic [AW-1:0] CTL_BASE   = 22'd16,
    parameter logic [AW-1:0] FILL_BASE  = 22'd8,
    parameter int            FILL_WORDS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CTLW-1:0] ctl_num,
    input  logic            chan_reset,
    input  logic            start,
    input  logic            start_write,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    input  logic [WW-1:0]   rd_data,
    input  logic            rd_valid,
    output logic            offer_valid,
    output logic [AW-1:0]   offer_addr,
    output logic [CW-1:0]   offer_cnt,
    output logic            offer_rev,
    output logic            offer_skip,
    output logic            offer_fill,
    input  logic            take_valid,
    input  logic [CW:0]     take_cnt,
    output logic            stopped,
    output logic            start_fail,
    input  logic            finish,
    input  logic            finish_store,
    input  logic            drive_left,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [WW-1:0]   wr_data,
    output logic            finish_done,
    output logic [AW-1:0]   list_ptr,
    output logic            chan_err,
    output logic            overrun_err
);
    walk_state_e    state_q;
    walk_flags_t    flags_q;
    logic [AW-1:0]  lp_q;
    logic [AW-1:0]  addr_q;
    logic [CW-1:0]  cnt_q;
    logic [OPW-1:0] op_q;
    logic           halt_q;
    logic           rev_q;
    logic           wr_q;
    logic           first_q;
    logic           stop_q;
    logic           fail_q;

    logic [AW-1:0]  area;
    cmd_t           cmd;
    logic           take_bad;
    logic [CW-1:0]  take_cnt_nxt;
    logic [AW-1:0]  take_addr_nxt;
    logic [WW-1:0]  stat_word;
    logic [WW-1:0]  ccw_word;
    logic           fin_left;
    logic           fin_need;

    assign area = CTL_BASE + {{(AW-CTLW-2){1'b0}}, ctl_num, 2'b00};

    ccl_decode u_decode (
        .word (rd_data),
        .cmd  (cmd)
    );

    ccl_offer #(
        .FILL_BASE  (FILL_BASE),
        .FILL_WORDS (FILL_WORDS)
    ) u_offer (
        .addr   (addr_q),
        .cnt    (cnt_q),
        .wr_dir (wr_q),
        .o_addr (offer_addr),
        .o_cnt  (offer_cnt),
        .skip   (offer_skip),
        .fill   (offer_fill)
    );

    ccl_consume u_consume (
        .take     (take_cnt),
        .rev      (rev_q),
        .cnt      (cnt_q),
        .addr     (addr_q),
        .bad      (take_bad),
        .nxt_cnt  (take_cnt_nxt),
        .nxt_addr (take_addr_nxt)
    );

    ccl_pack u_pack (
        .flags     (flags_q),
        .lp        (lp_q),
        .op        (op_q),
        .cnt       (cnt_q),
        .addr      (addr_q),
        .stat_word (stat_word),
        .ccw_word  (ccw_word)
    );

    always_comb begin
        fin_left = drive_left || (cnt_q != '0);
        fin_need = finish_store || fin_left || flags_q.chan_err;
    end

    always_ff @(posedge clk) begin
        if (rst || chan_reset) begin
            state_q <= S_IDLE;
            flags_q <= '0;
            lp_q    <= area;
            addr_q  <= '0;
            cnt_q   <= '0;
            op_q    <= '0;
            halt_q  <= 1'b1;
            rev_q   <= 1'b0;
            wr_q    <= 1'b0;
            first_q <= 1'b0;
            stop_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            stop_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        wr_q    <= start_write;
                        flags_q <= '0;
                        first_q <= 1'b1;
                        state_q <= S_REQ;
                    end else if (finish) begin
                        if (fin_left) begin
                            flags_q.chan_err <= 1'b1;
                            flags_q.long_wc  <= (cnt_q != '0);
                            flags_q.short_wc <= (cnt_q == '0);
                        end
                        state_q <= fin_need ? S_WST : S_DONE;
                    end
                end
                S_REQ: state_q <= S_WAIT;
                S_WAIT: begin
                    if (rd_valid) begin
                        unique case (cmd.kind)
                            K_END: begin
                                lp_q    <= cmd.addr;
                                cnt_q   <= '0;
                                halt_q  <= 1'b1;
                                stop_q  <= 1'b1;
                                fail_q  <= first_q;
                                state_q <= S_IDLE;
                            end
                            K_LINK: begin
                                lp_q    <= cmd.addr;
                                state_q <= S_REQ;
                            end
                            K_MOVE: begin
                                lp_q    <= lp_q + AW'(1);
                                cnt_q   <= cmd.cnt;
                                addr_q  <= cmd.addr;
                                halt_q  <= cmd.halt;
                                rev_q   <= cmd.rev;
                                op_q    <= cmd.op;
                                first_q <= 1'b0;
                                if (cmd.cnt != '0)
                                    state_q <= S_ACT;
                                else if (cmd.halt) begin
                                    stop_q  <= 1'b1;
                                    state_q <= S_IDLE;
                                end else
                                    state_q <= S_REQ;
                            end
                            default: begin
                                flags_q.chan_err <= 1'b1;
                                stop_q           <= 1'b1;
                                fail_q           <= first_q;
                                state_q          <= S_IDLE;
                            end
                        endcase
                    end
                end
                S_ACT: begin
                    if (finish) begin
                        if (fin_left) begin
                            flags_q.chan_err <= 1'b1;
                            flags_q.long_wc  <= (cnt_q != '0);
                            flags_q.short_wc <= (cnt_q == '0);
                        end
                        state_q <= fin_need ? S_WST : S_DONE;
                    end else if (take_valid) begin
                        if (take_bad) begin
                            flags_q.overrun <= 1'b1;
                            stop_q          <= 1'b1;
                            state_q         <= S_IDLE;
                        end else begin
                            cnt_q  <= take_cnt_nxt;
                            addr_q <= take_addr_nxt;
                            if (take_cnt_nxt == '0) begin
                                if (halt_q) begin
                                    stop_q  <= 1'b1;
                                    state_q <= S_IDLE;
                                end else
                                    state_q <= S_REQ;
                            end
                        end
                    end
                end
                S_WST:  state_q <= S_WCCW;
                S_WCCW: state_q <= S_DONE;
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req      = (state_q == S_REQ);
        rd_addr     = lp_q;
        offer_valid = (state_q == S_ACT);
        offer_rev   = rev_q;
        stopped     = stop_q;
        start_fail  = fail_q;
        wr_en       = (state_q == S_WST) || (state_q == S_WCCW);
        wr_addr     = (state_q == S_WCCW) ? (area + AW'(2)) : (area + AW'(1));
        wr_data     = (state_q == S_WCCW) ? ccw_word : stat_word;
        finish_done = (state_q == S_DONE);
        list_ptr    = lp_q;
        chan_err    = flags_q.chan_err;
        overrun_err = flags_q.overrun;
    end
endmodule

// File: rtl/ccl_walker_chk.sv
`timescale 1ns/1ps
module ccl_walker_chk
    import ccl_pkg::*;
#(
    parameter logic [AW-1:0] CTL_BASE   = 22'd16,
    parameter int            FILL_WORDS = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [CTLW-1:0] ctl_num,
    input logic            chan_reset,
    input logic [AW-1:0]   list_ptr,
    input logic            rd_req,
    input logic            offer_valid,
    input logic            offer_fill,
    input logic [CW-1:0]   offer_cnt,
    input logic            start_fail,
    input logic            stopped,
    input logic            overrun_err,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr
);
    logic [AW-1:0] area_now;
    assign area_now = CTL_BASE + {{(AW-CTLW-2){1'b0}}, ctl_num, 2'b00};

    // R1: a channel reset points the list at the controller's area
    a_r1_reset_ptr: assert property (@(posedge clk) disable iff (rst)
        chan_reset |=> (list_ptr == $past(area_now)));

    // R4: each read request lasts exactly one cycle
    a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R3: a failed start is always reported as a stop too
    a_r3_fail_is_stop: assert property (@(posedge clk) disable iff (rst)
        start_fail |-> stopped);

    // R8: a fill offer never exceeds the fill area and is never empty
    a_r8_fill_limit: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && offer_fill) |->
            ((offer_cnt <= CW'(FILL_WORDS)) && (offer_cnt != '0)));

    // R9: a new overrun ends the walk in the same cycle
    a_r9_overrun_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_err) |-> stopped);

    // R12: the status write is followed by the command word write
    a_r12_write_pair: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == area_now + AW'(1))) |=>
            (wr_en && (wr_addr == area_now + AW'(2))));
endmodule

bind ccl_walker ccl_walker_chk #(
    .CTL_BASE   (CTL_BASE),
    .FILL_WORDS (FILL_WORDS)
) u_chk (.*);

// File: tb/ccl_walker_test.sv
`timescale 1ns/1ps
module ccl_walker_test;
    import ccl_pkg::*;

    localparam logic [AW-1:0] BASE  = 22'd16;
    localparam logic [AW-1:0] FILLB = 22'd8;
    localparam int            FW    = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CTLW-1:0] ctl_num = 3'd1;
    logic            chan_reset = 1'b0, start = 1'b0, start_write = 1'b0;
    logic            rd_req, rd_valid = 1'b0;
    logic [AW-1:0]   rd_addr;
    logic [WW-1:0]   rd_data = '0;
    logic            offer_valid, offer_rev, offer_skip, offer_fill;
    logic [AW-1:0]   offer_addr;
    logic [CW-1:0]   offer_cnt;
    logic            take_valid = 1'b0;
    logic [CW:0]     take_cnt = '0;
    logic            stopped, start_fail;
    logic            finish = 1'b0, finish_store = 1'b0, drive_left = 1'b0;
    logic            wr_en, finish_done, chan_err, overrun_err;
    logic [AW-1:0]   wr_addr, list_ptr;
    logic [WW-1:0]   wr_data;

    ccl_walker #(.CTL_BASE(BASE), .FILL_BASE(FILLB), .FILL_WORDS(FW)) uut (.*);

    always #5 clk = ~clk;

    // memory model: one-cycle read latency, 64 words indexed by low address bits
    logic [WW-1:0] mem [64];
    logic [AW-1:0] ra0, ra1, ra2;
    always @(posedge clk) begin
        rd_valid <= rd_req;
        if (rd_req) begin
            rd_data <= mem[rd_addr[5:0]];
            ra2 <= ra1; ra1 <= ra0; ra0 <= rd_addr;
        end
    end

    int nvec = 0, nbad = 0;
    bit got_off, got_stop, got_fail, got_done;
    int w_n;
    logic [AW-1:0] w_a0, w_a1;
    logic [WW-1:0] w_d0, w_d1;

    task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] cw(input logic [2:0] op, input int cnt, input logic [AW-1:0] a);
        return {op, CW'(cnt), a};
    endfunction

    function automatic logic [WW-1:0] st(input bit ce, input bit ov, input bit lg,
                                         input bit sh, input bit nz, input logic [AW-1:0] lp);
        return {ce, ov, lg, sh, nz, 9'b0, lp};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = cw(3'b000, 0, 22'd60);
    endtask

    task automatic pulse_reset();
        @(negedge clk) chan_reset = 1'b1;
        @(negedge clk) chan_reset = 1'b0;
    endtask

    task automatic do_start(input bit w);
        @(negedge clk) begin start = 1'b1; start_write = w; end
        @(negedge clk) start = 1'b0;
    endtask

    task automatic settle();
        got_off = 0; got_stop = 0; got_fail = 0;
        for (int i = 0; i < 40; i++) begin
            if (stopped) begin got_stop = 1; got_fail = start_fail; return; end
            if (offer_valid) begin got_off = 1; return; end
            @(negedge clk);
        end
    endtask

    task automatic take(input int n);
        @(negedge clk) begin take_valid = 1'b1; take_cnt = (CW+1)'(n); end
        @(negedge clk) take_valid = 1'b0;
    endtask

    task automatic fin(input bit s, input bit dl);
        @(negedge clk) begin finish = 1'b1; finish_store = s; drive_left = dl; end
        @(negedge clk) finish = 1'b0;
        w_n = 0; got_done = 0;
        for (int i = 0; i < 10; i++) begin
            if (wr_en) begin
                if (w_n == 0) begin w_a0 = wr_addr; w_d0 = wr_data; end
                else begin w_a1 = wr_addr; w_d1 = wr_data; end
                w_n++;
            end
            if (finish_done) begin got_done = 1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        eq("R1 list_ptr after reset", list_ptr, 22'd20);
        eq("R1 no offer after reset", offer_valid, 1'b0);
        eq("R1 chan_err clear after reset", chan_err, 1'b0);
        eq("R1 no read after reset", rd_req, 1'b0);
        ctl_num = 3'd3;
        pulse_reset();
        eq("R1 list_ptr ctl 3", list_ptr, 22'd28);
        ctl_num = 3'd1;
        pulse_reset();
        eq("R1 list_ptr ctl 1", list_ptr, 22'd20);

        // R5 R6 R7 R8 R12: sweep of transfer variants, directions, address classes
        for (int cfg = 0; cfg < 24; cfg++) begin
            bit h, r, w;
            logic [AW-1:0] a0, ea, elp;
            int rem, k;
            h = cfg[0]; r = cfg[1]; w = cfg[2];
            a0 = (cfg / 8 == 0) ? 22'd0 : (cfg / 8 == 1) ? 22'd1000 : 22'h3FFFFD;
            clear_mem();
            mem[20] = cw({1'b1, h, r}, 9, a0);
            mem[21] = cw(3'b000, 0, 22'(50 + cfg));
            pulse_reset();
            do_start(w);
            settle();
            eq($sformatf("R5 cfg%0d offer present", cfg), got_off, 1'b1);
            eq($sformatf("R5 cfg%0d list_ptr step", cfg), list_ptr, 22'd21);
            rem = 9; ea = a0;
            while (rem > 0 && got_off) begin
                if (a0 == '0 && w) begin
                    eq($sformatf("R8 cfg%0d fill flag", cfg), offer_fill, 1'b1);
                    eq($sformatf("R8 cfg%0d fill addr", cfg), offer_addr, FILLB);
                    eq($sformatf("R8 cfg%0d fill cnt", cfg), offer_cnt, (rem > FW) ? FW : rem);
                end else if (a0 == '0) begin
                    eq($sformatf("R8 cfg%0d skip flag", cfg), offer_skip, 1'b1);
                    eq($sformatf("R8 cfg%0d skip cnt", cfg), offer_cnt, rem);
                end else begin
                    eq($sformatf("R6 cfg%0d addr", cfg), offer_addr, ea);
                    eq($sformatf("R6 cfg%0d cnt", cfg), offer_cnt, rem);
                    eq($sformatf("R5 cfg%0d rev", cfg), offer_rev, r);
                end
                k = (rem > FW) ? FW : rem;
                take(r ? -k : k);
                rem -= k;
                if (ea != '0) ea = ea + AW'(r ? -k : k);
                settle();
            end
            elp = h ? 22'd21 : 22'(50 + cfg);
            eq($sformatf("R7 cfg%0d stopped", cfg), got_stop, 1'b1);
            eq($sformatf("R7 cfg%0d no start_fail", cfg), got_fail, 1'b0);
            eq($sformatf("R7 cfg%0d list_ptr", cfg), list_ptr, elp);
            fin(1'b1, 1'b0);
            eq($sformatf("R12 cfg%0d writes", cfg), w_n, 2);
            eq($sformatf("R12 cfg%0d status addr", cfg), w_a0, 22'd21);
            eq($sformatf("R12 cfg%0d status word", cfg), w_d0, st(0, 0, 0, 0, 0, elp));
            eq($sformatf("R12 cfg%0d ccw addr", cfg), w_a1, 22'd22);
            eq($sformatf("R12 cfg%0d ccw word", cfg), w_d1, cw({1'b1, h, r}, 0, ea));
            eq($sformatf("R12 cfg%0d done", cfg), got_done, 1'b1);
        end

        // R3 R2: end-of-list at start
        clear_mem();
        mem[20] = cw(3'b000, 0, 22'd77);
        pulse_reset();
        do_start(1'b0);
        settle();
        eq("R3 stop on end word", got_stop, 1'b1);
        eq("R3 start_fail on end word", got_fail, 1'b1);
        eq("R3 list_ptr loaded", list_ptr, 22'd77);
        fin(1'b0, 1'b0);
        eq("R12 clean finish writes nothing", w_n, 0);
        eq("R12 clean finish done", got_done, 1'b1);

        // R4: chained links
        clear_mem();
        mem[20] = cw(3'b001, 0, 22'd30);
        mem[30] = cw(3'b001, 0, 22'd40);
        mem[40] = cw(3'b100, 3, 22'd500);
        pulse_reset();
        do_start(1'b0);
        settle();
        eq("R4 offer after links", got_off, 1'b1);
        eq("R4 first read", ra2, 22'd20);
        eq("R4 second read", ra1, 22'd30);
        eq("R4 third read", ra0, 22'd40);
        eq("R4 list_ptr after links", list_ptr, 22'd41);
        eq("R4 offer addr", offer_addr, 22'd500);
        eq("R4 offer cnt", offer_cnt, 11'd3);

        // R5: list pointer wraps modulo 2^22
        clear_mem();
        mem[20] = cw(3'b001, 0, 22'h3FFFFF);
        mem[63] = cw(3'b100, 2, 22'd100);
        pulse_reset();
        do_start(1'b0);
        settle();
        eq("R5 wrap offer", got_off, 1'b1);
        eq("R5 wrap list_ptr", list_ptr, 22'd0);

        // R10: undefined opcodes
        for (int u = 2; u < 4; u++) begin
            clear_mem();
            mem[20] = cw(3'(u), 5, 22'd123);
            pulse_reset();
            do_start(1'b1);
            settle();
            eq($sformatf("R10 op%0d stop", u), got_stop, 1'b1);
            eq($sformatf("R10 op%0d start_fail", u), got_fail, 1'b1);
            eq($sformatf("R10 op%0d chan_err", u), chan_err, 1'b1);
            fin(1'b0, 1'b0);
            eq($sformatf("R12 op%0d writes on error", u), w_n, 2);
            eq($sformatf("R12 op%0d status", u), w_d0, st(1, 0, 0, 0, 0, 22'd20));
            eq($sformatf("R12 op%0d ccw", u), w_d1, 36'd0);
        end

        // R9: overrun by magnitude, then finish reports long count (R11)
        clear_mem();
        mem[20] = cw(3'b100, 5, 22'd200);
        pulse_reset();
        do_start(1'b0);
        settle();
        take(6);
        settle();
        eq("R9 overrun stop", got_stop, 1'b1);
        eq("R9 overrun flag", overrun_err, 1'b1);
        fin(1'b0, 1'b0);
        eq("R11 overrun long writes", w_n, 2);
        eq("R11 overrun status", w_d0, st(1, 1, 1, 0, 1, 22'd21));
        eq("R9 count untouched", w_d1, cw(3'b100, 5, 22'd200));

        // R9: wrong sign in each direction
        for (int v = 0; v < 2; v++) begin
            clear_mem();
            mem[20] = cw(v ? 3'b101 : 3'b100, 4, 22'd300);
            pulse_reset();
            do_start(1'b0);
            settle();
            take(v ? 1 : -1);
            settle();
            eq($sformatf("R9 sign%0d stop", v), got_stop, 1'b1);
            eq($sformatf("R9 sign%0d flag", v), overrun_err, 1'b1);
        end

        // R11: short count when the drive still had work
        clear_mem();
        mem[20] = cw(3'b110, 2, 22'd300);
        pulse_reset();
        do_start(1'b0);
        settle();
        take(2);
        settle();
        fin(1'b0, 1'b1);
        eq("R11 short chan_err", chan_err, 1'b1);
        eq("R11 short status", w_d0, st(1, 0, 0, 1, 0, 22'd21));
        eq("R11 short ccw", w_d1, cw(3'b110, 0, 22'd302));

        // R11: finish mid-transfer gives long count
        clear_mem();
        mem[20] = cw(3'b100, 6, 22'd300);
        pulse_reset();
        do_start(1'b0);
        settle();
        take(2);
        settle();
        fin(1'b0, 1'b0);
        eq("R11 long status", w_d0, st(1, 0, 1, 0, 1, 22'd21));
        eq("R11 long ccw", w_d1, cw(3'b100, 4, 22'd302));

        // R7: chain from one transfer into the next
        clear_mem();
        mem[20] = cw(3'b100, 2, 22'd400);
        mem[21] = cw(3'b110, 1, 22'd600);
        pulse_reset();
        do_start(1'b0);
        settle();
        take(2);
        settle();
        eq("R7 second offer", got_off, 1'b1);
        eq("R7 second addr", offer_addr, 22'd600);
        eq("R7 second list_ptr", list_ptr, 22'd22);
        take(1);
        settle();
        eq("R7 halt after second", got_stop, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule